// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status, Mask and Acknowledge

This block holds the interrupt state of an Ethernet controller. It keeps a raw status word with one bit per interrupt source, a mask word that enables each source, and a single interrupt line. Event sources such as the receive path, the transmit path and the management interface each drive a one-cycle pulse on their own bit of `evt_set`. That pulse sets the matching status bit, and the bit stays set until software clears it.

Software reaches the block through a simple register port. Reading offset 0x00 returns the raw status. Writing offset 0x00 clears every status bit whose bit in the written word is one. Offset 0x04 holds the mask, and the host can both read and write it. The interrupt line is high whenever a status bit and its mask bit are both set. If an acknowledge write clears the transmit-error bit, the block also sends a one-cycle reset pulse to the transmit frame assembler, so that a half-built frame is thrown away.

The interrupt line is driven from registers through a single AND-OR level. A change to the status or to the mask shows on the line in the cycle right after the clock edge that stores the change.

Top module: `eth_irq_ctrl`

## Requirements
- R1: After reset the status is 0x00, the mask is 0x7F (all seven sources enabled), `irq_out` is low and `tx_rst_pulse` is low.
- R2: Bit k of `evt_set` sets status bit k at the next clock edge. The source encoding is: bit 0 receive, bit 1 transmit error, bit 2 transmit empty, bit 3 FIFO overflow, bit 4 receive error, bit 5 management done, bit 6 PHY.
- R3: `bus_rdata` depends only on `bus_addr` and is combinational. Offset 0x00 returns the status in bits 6:0. Offset 0x04 returns the mask in bits 6:0. The upper bits are zero, and every other offset reads as zero.
- R4: A write to offset 0x00 clears each status bit whose written bit is 1. Status bits whose written bit is 0 keep their value.
- R5: If an event pulse and an acknowledge of the same bit happen in the same cycle, the bit ends up set.
- R6: A write to offset 0x04 loads the mask from write-data bits 6:0. Bits 31:7 have no effect.
- R7: `irq_out` equals the OR of (status AND mask). It tracks the register values from the clock edge that updates them.
- R8: A write to offset 0x00 with write-data bit 1 set makes `tx_rst_pulse` high for exactly the one cycle after that edge. No other access raises it.
- R9: Writes to any offset other than 0x00 and 0x04 change neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 7 | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Interrupt request, high while any enabled status bit is set |
| tx_rst_pulse | output | 1 | One-cycle reset for the transmit frame state |

## Verification
The hardest situation to create is the collision between an event pulse and an acknowledge write to the same bit, in the same cycle. Set-over-clear priority is visible only then. The bench creates it on purpose. For each source it fires that source's event together with an all-ones acknowledge, and then reads back the status. Two further sweeps cover every value. One sweep walks all 128 acknowledge patterns against a fully set status. The other walks all 128 mask values against a fixed status. In every case the bench works out the expected status and interrupt level with its own arithmetic.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
    localparam int NSRC = 7;

    typedef enum int {
        SRC_RX      = 0,
        SRC_TXERR   = 1,
        SRC_TXEMPTY = 2,
        SRC_FIFOOV  = 3,
        SRC_RXERR   = 4,
        SRC_MGMT    = 5,
        SRC_PHY     = 6
    } irq_src_e;

    localparam int OFS_ACK  = 'h00;
    localparam int OFS_MASK = 'h04;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import eth_irq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NSRC-1:0]   status_q,
    input  logic [NSRC-1:0]   mask_q,
    output logic              ack_we,
    output logic              mask_we,
    output logic [NSRC-1:0]   wr_bits,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int PAD_W = DATA_W - NSRC;

    logic hit_ack;
    logic hit_mask;
    logic unused_hi;

    assign hit_ack   = (bus_addr == ADDR_W'(OFS_ACK));
    assign hit_mask  = (bus_addr == ADDR_W'(OFS_MASK));
    assign ack_we    = bus_wr && hit_ack;
    assign mask_we   = bus_wr && hit_mask;
    assign wr_bits   = bus_wdata[NSRC-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:NSRC];

    always_comb begin
        bus_rdata = '0;
        if (hit_ack)
            bus_rdata = {{PAD_W{1'b0}}, status_q};
        else if (hit_mask)
            bus_rdata = {{PAD_W{1'b0}}, mask_q};
    end

    always_comb begin
        assert_onehot_strobe_R9: assert (!(ack_we && mask_we));
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import eth_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_set,
    input  logic            ack_we,
    input  logic [NSRC-1:0] ack_bits,
    output logic [NSRC-1:0] status_q
);
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] status_d;

    assign clr_vec = ack_we ? ack_bits : '0;

    // set wins over clear, bit by bit
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_bit
            assign status_d[i] = evt_set[i] | (status_q[i] & ~clr_vec[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> ((status_q & $past(ack_bits & ~evt_set)) == '0));

    assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set == '0) |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import eth_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_bits,
    output logic [NSRC-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_bits;
    end

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_bits)));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/eth_irq_ctrl.sv
module eth_irq_ctrl
    import eth_irq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_set,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              tx_rst_pulse
);
    logic            ack_we;
    logic            mask_we;
    logic [NSRC-1:0] wr_bits;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] mask_q;

    irq_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status_q  (status_q),
        .mask_q    (mask_q),
        .ack_we    (ack_we),
        .mask_we   (mask_we),
        .wr_bits   (wr_bits),
        .bus_rdata (bus_rdata)
    );

    irq_status_bank u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .ack_we   (ack_we),
        .ack_bits (wr_bits),
        .status_q (status_q)
    );

    irq_mask_reg u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we),
        .mask_bits (wr_bits),
        .mask_q    (mask_q)
    );

    assign irq_out = |(status_q & mask_q);

    always_ff @(posedge clk) begin
        if (!rst_n) tx_rst_pulse <= 1'b0;
        else        tx_rst_pulse <= ack_we && wr_bits[SRC_TXERR];
    end

    assert_quiet_when_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq_out);

    assert_txrst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst_pulse |=> !tx_rst_pulse || $past(ack_we));

    assert_txrst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && bus_wdata[SRC_TXERR]) |=> tx_rst_pulse);
endmodule

// File: tb/eth_irq_ctrl_tb.sv
module eth_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_set = '0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic        tx_rst_pulse;

    int total = 0;
    int bad = 0;
    logic [6:0] m_st;
    logic [6:0] m_mk;
    logic       m_txr;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .tx_rst_pulse(tx_rst_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one clock cycle of stimulus, model updated after the edge
    task automatic step(input logic [6:0] ev, input logic wr, input logic [5:0] ad, input logic [31:0] wd);
        evt_set = ev; bus_wr = wr; bus_addr = ad; bus_wdata = wd;
        @(posedge clk);
        #1;
        if (wr && ad == 6'h00) m_st = m_st & ~wd[6:0];
        m_st = m_st | ev;
        if (wr && ad == 6'h04) m_mk = wd[6:0];
        m_txr = wr && ad == 6'h00 && wd[1];
        evt_set = '0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic check_all(input string tag);
        bus_addr = 6'h00; #1;
        chk({tag, " R3 status"}, bus_rdata, {25'd0, m_st});
        bus_addr = 6'h04; #1;
        chk({tag, " R3 mask"}, bus_rdata, {25'd0, m_mk});
        chk({tag, " R7 irq"}, {31'd0, irq_out}, {31'd0, |(m_st & m_mk)});
        chk({tag, " R8 txrst"}, {31'd0, tx_rst_pulse}, {31'd0, m_txr});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_st = '0; m_mk = 7'h7F; m_txr = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1 reset");

        // R2: each source sets its own bit
        for (int k = 0; k < NS; k++) begin
            step(7'(1 << k), 1'b0, 6'h00, 32'd0);
            check_all("R2 event");
            step(7'h00, 1'b1, 6'h00, 32'h7F);
            check_all("R4 ack all");
        end

        // R4/R8: all 128 ack patterns against full status
        for (int v = 0; v < 128; v++) begin
            step(7'h7F, 1'b0, 6'h00, 32'd0);
            step(7'h00, 1'b1, 6'h00, {25'h1ABCDEF, 7'(v)});
            check_all("R4 ack sweep");
            step(7'h00, 1'b0, 6'h00, 32'd0);
            chk("R8 pulse ends", {31'd0, tx_rst_pulse}, 32'd0);
        end

        // R5: event and ack of same bit collide
        for (int k = 0; k < NS; k++) begin
            step(7'h00, 1'b1, 6'h00, 32'h7F);
            step(7'(1 << k), 1'b1, 6'h00, 32'hFFFF_FFFF);
            check_all("R5 set wins");
        end

        // R6/R7: all 128 mask values, upper data bits junk
        step(7'h00, 1'b1, 6'h00, 32'h7F);
        step(7'h25, 1'b0, 6'h00, 32'd0);
        for (int v = 0; v < 128; v++) begin
            step(7'h00, 1'b1, 6'h04, {25'h155AA33, 7'(v)});
            check_all("R6 mask sweep");
        end

        // R9: other offsets ignored, read zero
        for (int a = 0; a < 64; a++) begin
            if (a != 0 && a != 4) begin
                step(7'h00, 1'b1, 6'(a), 32'hFFFF_FFFF);
                bus_addr = 6'(a); #1;
                chk("R9 other offset read", bus_rdata, 32'd0);
                check_all("R9 no effect");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule